// File: doc/BRIEF.md
# Dual-Mask Level Interrupt Controller

This block collects a vector of level-sensitive interrupt sources and drives two request lines toward a processor: a normal request and a fast request. The two requests read the same raw level vector. Each request has its own enable mask. Software changes a mask through a pair of addresses. One address sets the bits that are one in the written data, and the other clears them. There is no read-modify-write. Software can read the raw levels, both masks and both masked views at any time.

Source 0 is shared with a software interrupt flag. A write to one address raises the flag and a write to another address lowers it, so firmware can trigger its own interrupt. The normal request output of one instance can be wired into a source input of a second instance to build a cascade. The register bus is word addressed. Reads are combinational and have no side effects. Writes take effect at the clock edge where the write strobe is high.

Top module: `dual_mask_intc`

## Requirements
- R1: After reset both enable masks and the software flag are zero, and `irq_o` and `fiq_o` are low.
- R2: Reading word 1 or word 9 returns the raw level vector. Bit 0 of that vector is the OR of `src_in[0]` and the software flag. Every other bit equals its source input.
- R3: Writing word 2 ORs the written data into the normal-request mask. Reading word 2 returns that mask.
- R4: Writing word 3 clears every bit of the normal-request mask that is one in the written data.
- R5: Words 10 (set, and read back) and 11 (clear) manage the fast-request mask in the same way. Writes to them leave the normal-request mask unchanged, and writes to words 2 and 3 leave the fast-request mask unchanged.
- R6: Reading word 0 returns the raw levels ANDed with the normal-request mask. Reading word 8 returns the raw levels ANDed with the fast-request mask.
- R7: A write to word 4 with data bit 0 set raises the software flag. A write to word 5 with data bit 0 set lowers it. Such a write with data bit 0 clear has no effect. Reading word 4 returns raw bit 0 in bit 0, with all other bits zero.
- R8: Reads of words 3, 5 and 11 return zero. Writes to words 0, 1, 8 and 9 change no mask and do not change the software flag.
- R9: `irq_o` is high exactly one clock after the word-0 masked status is nonzero. `fiq_o` follows the word-8 masked status in the same way. In particular, an all-zero mask holds its output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (4) | Word address of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| src_in | input | NUM_SRC (32) | Level-sensitive interrupt sources |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The hardest case to reach is the merge on source 0. The software flag and external input 0 land on the same raw bit, so a bug in how the flag is set or cleared can hide behind the external level. The stimulus holds `src_in` at zero while it writes the software words. It first writes with bit 0 clear and all other bits set, then with bit 0 set, and reads word 4, word 1 and the request output after each write. A second concern is independence between the two masks. The stimulus loads different patterns into the two masks and then sweeps a single active source across all 32 positions, so every bit of both masked views and both outputs is checked against the expected AND.

// File: rtl/dmi_pkg.sv
package dmi_pkg;
   // word offsets of the register map
   localparam int unsigned W_IRQ_MSK  = 0;
   localparam int unsigned W_IRQ_RAW  = 1;
   localparam int unsigned W_IRQ_EN   = 2;
   localparam int unsigned W_IRQ_DIS  = 3;
   localparam int unsigned W_SW_SET   = 4;
   localparam int unsigned W_SW_CLR   = 5;
   localparam int unsigned W_FIQ_MSK  = 8;
   localparam int unsigned W_FIQ_RAW  = 9;
   localparam int unsigned W_FIQ_EN   = 10;
   localparam int unsigned W_FIQ_DIS  = 11;
   localparam int unsigned MIN_ADDR_W = 4;

   typedef enum logic {CH_IRQ = 1'b0, CH_FIQ = 1'b1} req_ch_e;
endpackage

// File: rtl/dmi_mask_reg.sv
module dmi_mask_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      mask_q <= '0;
      else if (set_en) mask_q <= mask_q | wdata;
      else if (clr_en) mask_q <= mask_q & ~wdata;
   end

   a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> ((mask_q & $past(wdata)) == $past(wdata)));
   a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en) |=> ((mask_q & $past(wdata)) == '0));
   a_r8_hold_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en && !clr_en) |=> $stable(mask_q));
endmodule

// File: rtl/dmi_soft_flag.sv
module dmi_soft_flag #(
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raise,
   input  logic lower,
   output logic flag_q
);
   generate
      if (ENABLE) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)     flag_q <= 1'b0;
            else if (raise) flag_q <= 1'b1;
            else if (lower) flag_q <= 1'b0;
         end
         a_r7_soft_raise: assert property (@(posedge clk) disable iff (!rst_n)
            raise |=> flag_q);
         a_r7_soft_lower: assert property (@(posedge clk) disable iff (!rst_n)
            (lower && !raise) |=> !flag_q);
      end else begin : g_none
         logic unused_ok;
         assign unused_ok = clk ^ rst_n ^ raise ^ lower;
         assign flag_q = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dmi_req_stage.sv
module dmi_req_stage #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] status,
   output logic         req_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= |status;
   end
endmodule

// File: rtl/dual_mask_intc.sv
module dual_mask_intc #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter bit          SOFT_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] src_in,
   output logic               irq_o,
   output logic               fiq_o
);
   import dmi_pkg::*;

   localparam int unsigned NCH = 2;

   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("NUM_SRC must lie in 1..DATA_W");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic               sw_flag;
   logic [NUM_SRC-1:0] raw;
   logic [NUM_SRC-1:0] mask  [NCH];
   logic [NUM_SRC-1:0] gated [NCH];
   logic [NCH-1:0]     req;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
      return a == ADDR_W'(ofs);
   endfunction

   function automatic logic [DATA_W-1:0] zext(input logic [NUM_SRC-1:0] v);
      logic [DATA_W-1:0] r;
      r = '0;
      r[NUM_SRC-1:0] = v;
      return r;
   endfunction

   dmi_soft_flag #(.ENABLE(SOFT_EN)) u_soft (
      .clk    (clk),
      .rst_n  (rst_n),
      .raise  (bus_wr && hit(bus_addr, W_SW_SET) && bus_wdata[0]),
      .lower  (bus_wr && hit(bus_addr, W_SW_CLR) && bus_wdata[0]),
      .flag_q (sw_flag)
   );

   // source 0 merges the software flag
   always_comb begin
      raw    = src_in;
      raw[0] = src_in[0] | sw_flag;
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         localparam int unsigned OFS_SET = (c == int'(CH_IRQ)) ? W_IRQ_EN  : W_FIQ_EN;
         localparam int unsigned OFS_CLR = (c == int'(CH_IRQ)) ? W_IRQ_DIS : W_FIQ_DIS;

         dmi_mask_reg #(.W(NUM_SRC)) u_mask (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (bus_wr && hit(bus_addr, OFS_SET)),
            .clr_en (bus_wr && hit(bus_addr, OFS_CLR)),
            .wdata  (bus_wdata[NUM_SRC-1:0]),
            .mask_q (mask[c])
         );

         assign gated[c] = raw & mask[c];

         dmi_req_stage #(.W(NUM_SRC)) u_req (
            .clk    (clk),
            .rst_n  (rst_n),
            .status (gated[c]),
            .req_q  (req[c])
         );
      end
   endgenerate

   assign irq_o = req[CH_IRQ];
   assign fiq_o = req[CH_FIQ];

   always_comb begin
      bus_rdata = '0;
      if      (hit(bus_addr, W_IRQ_MSK)) bus_rdata = zext(gated[CH_IRQ]);
      else if (hit(bus_addr, W_IRQ_RAW)) bus_rdata = zext(raw);
      else if (hit(bus_addr, W_IRQ_EN))  bus_rdata = zext(mask[CH_IRQ]);
      else if (hit(bus_addr, W_SW_SET))  bus_rdata[0] = raw[0];
      else if (hit(bus_addr, W_FIQ_MSK)) bus_rdata = zext(gated[CH_FIQ]);
      else if (hit(bus_addr, W_FIQ_RAW)) bus_rdata = zext(raw);
      else if (hit(bus_addr, W_FIQ_EN))  bus_rdata = zext(mask[CH_FIQ]);
   end

   a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask[CH_IRQ] == '0) |=> !irq_o);
   a_r9_fiq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask[CH_FIQ] == '0) |=> !fiq_o);
   a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_in & mask[CH_IRQ]) != '0) |=> irq_o);
   a_r8_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (hit(bus_addr, W_IRQ_MSK) || hit(bus_addr, W_FIQ_RAW)))
      |=> ($stable(mask[CH_IRQ]) && $stable(mask[CH_FIQ]) && $stable(sw_flag)));
endmodule

// File: tb/sim_dual_mask_intc.sv
module sim_dual_mask_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] src_in = '0;
   logic        irq_o, fiq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_ien = '0, m_fen = '0;
   logic        m_sw = 1'b0;

   always #2 clk = ~clk;

   dual_mask_intc u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
      .irq_o(irq_o), .fiq_o(fiq_o)
   );

   function automatic logic [31:0] m_raw();
      return src_in | {31'b0, m_sw};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      case (a)
         2:  m_ien = m_ien | d;
         3:  m_ien = m_ien & ~d;
         10: m_fen = m_fen | d;
         11: m_fen = m_fen & ~d;
         4:  if (d[0]) m_sw = 1'b1;
         5:  if (d[0]) m_sw = 1'b0;
         default: ;
      endcase
   endtask

   task automatic rd(input string req, input int a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = 4'(a);
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic outs(input string req);
      @(posedge clk);
      @(negedge clk);
      chk(req, {31'b0, irq_o}, {31'b0, |(m_raw() & m_ien)});
      chk(req, {31'b0, fiq_o}, {31'b0, |(m_raw() & m_fen)});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
      chk("R1 fiq_o", {31'b0, fiq_o}, 32'h0);
      rd("R1 irq mask", 2, 32'h0);
      rd("R1 fiq mask", 10, 32'h0);
      rd("R1 soft", 4, 32'h0);

      // R2 raw levels, one source at a time
      for (int i = 0; i < 32; i++) begin
         @(negedge clk); src_in = 32'h1 << i;
         rd("R2 raw word1", 1, m_raw());
         rd("R2 raw word9", 9, m_raw());
         rd("R6 unmasked", 0, 32'h0);
      end
      @(negedge clk); src_in = 32'h0;

      // R3 / R4 / R5 mask set and clear
      wr(2, 32'h0000_00F0);
      wr(2, 32'h0000_0F00);
      rd("R3 irq mask or", 2, m_ien);
      wr(3, 32'h0000_00F0);
      rd("R4 irq mask clear", 2, m_ien);
      wr(10, 32'hA5A5_0001);
      rd("R5 fiq mask set", 10, m_fen);
      rd("R5 irq mask untouched", 2, 32'h0000_0F00);
      wr(11, 32'h2000_0000);
      rd("R5 fiq mask clear", 10, m_fen);
      wr(2, 32'h8000_0001);
      wr(3, 32'h0000_0100);
      rd("R5 fiq untouched by irq writes", 10, 32'h85A5_0001);

      // R6 / R9 sweep one active source over both masked views
      for (int i = 0; i < 32; i++) begin
         @(negedge clk); src_in = 32'h1 << i;
         rd("R6 irq masked", 0, m_raw() & m_ien);
         rd("R6 fiq masked", 8, m_raw() & m_fen);
         outs("R9 outputs");
      end
      @(negedge clk); src_in = 32'hFFFF_FFFF;
      outs("R9 all sources");
      @(negedge clk); src_in = 32'h0;
      outs("R9 idle");

      // R7 software flag
      wr(4, 32'hFFFF_FFFE);
      rd("R7 soft set bit0 clear ignored", 4, 32'h0);
      wr(4, 32'h0000_0001);
      rd("R7 soft set", 4, 32'h1);
      rd("R7 raw shows soft", 1, 32'h1);
      outs("R7 soft drives requests");
      wr(5, 32'hFFFF_FFFE);
      rd("R7 soft clear bit0 clear ignored", 4, 32'h1);
      @(negedge clk); src_in = 32'hFFFF_FFFE;
      rd("R7 soft read bit0 only", 4, 32'h1);
      @(negedge clk); src_in = 32'h0;
      wr(5, 32'h0000_0001);
      rd("R7 soft cleared", 4, 32'h0);
      outs("R7 requests drop");

      // R8 clear-only reads and read-only writes
      rd("R8 read word3", 3, 32'h0);
      rd("R8 read word5", 5, 32'h0);
      rd("R8 read word11", 11, 32'h0);
      wr(0, 32'hFFFF_FFFF);
      wr(1, 32'hFFFF_FFFF);
      wr(8, 32'hFFFF_FFFF);
      wr(9, 32'hFFFF_FFFF);
      rd("R8 irq mask kept", 2, 32'h8000_0E01);
      rd("R8 fiq mask kept", 10, 32'h85A5_0001);
      rd("R8 soft kept", 4, 32'h0);
      outs("R8 outputs kept");

      // R9 zero mask holds output low
      wr(3, 32'hFFFF_FFFF);
      @(negedge clk); src_in = 32'hFFFF_FFFF;
      outs("R9 empty irq mask");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule